// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block watches the single-bit output of an infrared receiver and reduces it to a stream of one-byte run codes. A prescaler turns the base clock into a sample strobe. Each sample is taken after an optional polarity flip and passes through a glitch filter. An encoder state machine then measures how many samples each level lasts and emits one code per run. A long silence on the line closes the packet with a one-cycle end pulse. Downstream logic (a FIFO, a protocol decoder) consumes the codes. This block stores nothing and decodes no protocol.

The encoder state machine has four states. `S_OFF` is held while the enable is low. `S_WAIT` waits for the first active sample of a packet. `S_MARK` counts pulse samples and `S_SPACE` counts space samples. Its transitions are:
- enable rise (`S_OFF`→`S_WAIT`);
- first pulse (`S_WAIT`→`S_MARK`);
- pulse end (`S_MARK`→`S_SPACE`, emits the pulse code);
- space end (`S_SPACE`→`S_MARK`, emits any partial space code);
- idle timeout (`S_SPACE`→`S_WAIT`, emits the closing space code and the end pulse);
- disable (any state→`S_OFF`).

A run that outlasts one code's range is split into full-range codes of the same level, followed by one code for the rest of the run.

Top module: `ir_run_sampler`

## Requirements
- R1: One sample is taken every 64 clock cycles while enabled. A 1-sample pulse applied at enable produces its code with `code_valid` high 129 clock edges after the enable was raised.
- R2: Each code holds the run level in bit 7, where 1 means pulse and 0 means space. Bits 6:0 hold the run length in samples minus one.
- R3: A run longer than 128 samples is emitted as consecutive 0x7F-length codes of its level, followed by one code for the remainder. A run of exactly 128 samples gives one code and nothing more.
- R4: With `invert` high, a low `ir_in` is a pulse. The codes are the same as for the non-inverted waveform.
- R5: A change of level that lasts no more than `noise_thr` samples is merged into the surrounding run. A change that lasts `noise_thr`+1 samples or more starts a new run. Run lengths are kept, and the change point moves by the filter delay.
- R6: When a space run reaches (`idle_thr`+1)×128 samples, the block emits a last space code of 0x7F. In the same cycle it raises `pkt_end` for one clock.
- R7: No code is emitted while the line is a space before the first pulse of a packet, or after a packet end until the next pulse.
- R8: With `en` low, all counters clear, a partial run is dropped without a code, and `code_valid` and `pkt_end` stay low.
- R9: `code_valid` is high for exactly one clock per code.
- R10: After reset, `code_valid` and `pkt_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable. Low clears all state |
| invert | input | 1 | Flip the input polarity |
| noise_thr | input | 6 | Longest level change, in samples, treated as a glitch |
| idle_thr | input | 8 | Idle timeout N; a packet ends after (N+1)×128 space samples |
| ir_in | input | 1 | Raw receiver line |
| code_valid | output | 1 | One-clock strobe per emitted code |
| code | output | 8 | Run code: level in bit 7, length-1 in bits 6:0 |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
The bench checks the split points around 128 samples: exactly 128, 129 and 300 samples. A design that waits for the 129th sample before flushing a chunk, or that flushes when the count wraps, would emit an extra code or give a length that is off by one. Glitches of exactly `noise_thr` and `noise_thr`+1 samples are applied both mid-packet and while idle. A filter that is off by one would either split the merged 22-sample pulse or swallow the 3-sample space. The bench checks that the idle timeout lands on the same sample as the last full space chunk, so that no extra partial space code appears before `pkt_end`. It also lowers the enable in the middle of a pulse, and a design that flushed the partial run there would produce a code the scoreboard does not expect.

// File: rtl/ir_samp_pkg.sv
package ir_samp_pkg;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_WAIT  = 2'd1,
        S_MARK  = 2'd2,
        S_SPACE = 2'd3
    } enc_state_t;

    localparam int unsigned SAMPLE_DIV = 64;
    localparam int unsigned LEN_BITS   = 7;
    localparam int unsigned IDLE_UNIT_BITS = 7;

endpackage

// File: rtl/ir_samp_prescaler.sv
module ir_samp_prescaler #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    assign tick = en && (div_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!en || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_samp_filter.sv
module ir_samp_filter #(
    parameter int unsigned THR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             raw_lvl,
    input  logic [THR_W-1:0] thr,
    output logic             s_valid,
    output logic             s_lvl
);
    logic             held_lvl;
    logic [THR_W-1:0] odd_cnt;
    logic             nx_lvl;
    logic [THR_W-1:0] nx_cnt;

    always_comb begin
        nx_lvl = held_lvl;
        nx_cnt = '0;
        if (raw_lvl != held_lvl) begin
            if (odd_cnt >= thr) begin
                nx_lvl = raw_lvl;
            end else begin
                nx_cnt = odd_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_lvl <= 1'b0;
            odd_cnt  <= '0;
            s_valid  <= 1'b0;
            s_lvl    <= 1'b0;
        end else if (!en) begin
            held_lvl <= 1'b0;
            odd_cnt  <= '0;
            s_valid  <= 1'b0;
            s_lvl    <= 1'b0;
        end else begin
            s_valid <= tick;
            if (tick) begin
                held_lvl <= nx_lvl;
                odd_cnt  <= nx_cnt;
                s_lvl    <= nx_lvl;
            end
        end
    end
endmodule

// File: rtl/ir_samp_encoder.sv
module ir_samp_encoder
    import ir_samp_pkg::*;
#(
    parameter int unsigned LEN_W  = 7,
    parameter int unsigned IDLE_W = 8,
    parameter int unsigned UNIT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              s_valid,
    input  logic              s_lvl,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic              code_valid,
    output logic [LEN_W:0]    code,
    output logic              pkt_end
);
    localparam int unsigned IDLE_CW = IDLE_W + UNIT_W + 1;
    localparam logic [LEN_W:0]   FULL_RUN = (LEN_W+1)'(1) << LEN_W;
    localparam logic [LEN_W-1:0] MAX_LEN  = {LEN_W{1'b1}};

    enc_state_t         state_q, state_d;
    logic [LEN_W-1:0]   run_q, run_d;
    logic [IDLE_CW-1:0] idle_q, idle_d;
    logic               emit_d, end_d;
    logic [LEN_W:0]     code_d;

    logic [LEN_W:0]     run_inc;
    logic [IDLE_CW-1:0] idle_inc;
    logic [IDLE_CW-1:0] idle_limit;
    logic [LEN_W-1:0]   run_less1;

    assign run_inc    = {1'b0, run_q} + 1'b1;
    assign idle_inc   = idle_q + 1'b1;
    assign idle_limit = IDLE_CW'({1'b0, idle_thr} + 1'b1) << UNIT_W;
    assign run_less1  = run_q - 1'b1;

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        idle_d  = idle_q;
        emit_d  = 1'b0;
        end_d   = 1'b0;
        code_d  = '0;
        if (!en) begin
            state_d = S_OFF;
            run_d   = '0;
            idle_d  = '0;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    state_d = S_WAIT;
                end
                S_WAIT: begin
                    if (s_valid && s_lvl) begin
                        state_d = S_MARK;
                        run_d   = LEN_W'(1);
                        idle_d  = '0;
                    end
                end
                S_MARK: begin
                    if (s_valid) begin
                        if (s_lvl) begin
                            if (run_inc == FULL_RUN) begin
                                emit_d = 1'b1;
                                code_d = {1'b1, MAX_LEN};
                                run_d  = '0;
                            end else begin
                                run_d = run_inc[LEN_W-1:0];
                            end
                        end else begin
                            if (run_q != '0) begin
                                emit_d = 1'b1;
                                code_d = {1'b1, run_less1};
                            end
                            state_d = S_SPACE;
                            run_d   = LEN_W'(1);
                            idle_d  = IDLE_CW'(1);
                        end
                    end
                end
                S_SPACE: begin
                    if (s_valid) begin
                        if (s_lvl) begin
                            if (run_q != '0) begin
                                emit_d = 1'b1;
                                code_d = {1'b0, run_less1};
                            end
                            state_d = S_MARK;
                            run_d   = LEN_W'(1);
                            idle_d  = '0;
                        end else if (idle_inc == idle_limit) begin
                            emit_d  = 1'b1;
                            end_d   = 1'b1;
                            code_d  = {1'b0, MAX_LEN};
                            state_d = S_WAIT;
                            run_d   = '0;
                            idle_d  = '0;
                        end else if (run_inc == FULL_RUN) begin
                            emit_d = 1'b1;
                            code_d = {1'b0, MAX_LEN};
                            run_d  = '0;
                            idle_d = idle_inc;
                        end else begin
                            run_d  = run_inc[LEN_W-1:0];
                            idle_d = idle_inc;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            run_q   <= '0;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            idle_q  <= idle_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            code       <= '0;
            pkt_end    <= 1'b0;
        end else begin
            code_valid <= emit_d;
            pkt_end    <= end_d;
            if (emit_d) begin
                code <= code_d;
            end
        end
    end
endmodule

// File: rtl/ir_run_sampler.sv
module ir_run_sampler
    import ir_samp_pkg::*;
#(
    parameter int unsigned DIV     = SAMPLE_DIV,
    parameter int unsigned LEN_W   = LEN_BITS,
    parameter int unsigned NOISE_W = 6,
    parameter int unsigned IDLE_W  = 8,
    parameter int unsigned UNIT_W  = IDLE_UNIT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    input  logic               ir_in,
    output logic               code_valid,
    output logic [LEN_W:0]     code,
    output logic               pkt_end
);
    logic smp_tick;
    logic raw_lvl;
    logic flt_valid;
    logic flt_lvl;

    assign raw_lvl = ir_in ^ invert;

    ir_samp_prescaler #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (smp_tick)
    );

    ir_samp_filter #(.THR_W(NOISE_W)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (smp_tick),
        .raw_lvl (raw_lvl),
        .thr     (noise_thr),
        .s_valid (flt_valid),
        .s_lvl   (flt_lvl)
    );

    ir_samp_encoder #(
        .LEN_W  (LEN_W),
        .IDLE_W (IDLE_W),
        .UNIT_W (UNIT_W)
    ) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .s_valid    (flt_valid),
        .s_lvl      (flt_lvl),
        .idle_thr   (idle_thr),
        .code_valid (code_valid),
        .code       (code),
        .pkt_end    (pkt_end)
    );
endmodule

// File: rtl/ir_run_sampler_chk.sv
module ir_run_sampler_chk #(
    parameter int unsigned LEN_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           tick,
    input logic           s_valid,
    input logic           code_valid,
    input logic [LEN_W:0] code,
    input logic           pkt_end
);
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_code_follows_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(s_valid));

    p_end_closes_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (code_valid && code == {1'b0, {LEN_W{1'b1}}}));

    p_end_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!code_valid && !pkt_end));

    p_one_clk_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);
endmodule

bind ir_run_sampler ir_run_sampler_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (smp_tick),
    .s_valid    (flt_valid),
    .code_valid (code_valid),
    .code       (code),
    .pkt_end    (pkt_end)
);

// File: tb/ir_run_sampler_tb_top.sv
module ir_run_sampler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SMP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       invert = 1'b0;
    logic [5:0] noise_thr = '0;
    logic [7:0] idle_thr = '0;
    logic       ir_in = 1'b0;
    logic       code_valid;
    logic [7:0] code;
    logic       pkt_end;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int t0 = 0;
    bit arm_t = 0;
    bit done = 0;
    bit prev_valid = 0;
    string tag = "R10";
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    ir_run_sampler dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .invert     (invert),
        .noise_thr  (noise_thr),
        .idle_thr   (idle_thr),
        .ir_in      (ir_in),
        .code_valid (code_valid),
        .code       (code),
        .pkt_end    (pkt_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected run: level in bit 7, length-1 in bits 6:0, chunks of 128
    task automatic push_run(input bit lvl, input int len);
        int left = len;
        while (left > 128) begin
            exp_q.push_back({1'b0, lvl, 7'h7F});
            left -= 128;
        end
        exp_q.push_back({1'b0, lvl, 7'(left - 1)});
    endtask

    task automatic push_end();
        exp_q.push_back({1'b0, 8'h7F});
        exp_q.push_back(9'h100);
    endtask

    task automatic drive(input bit lvl, input int samples);
        ir_in = lvl ^ invert;
        repeat (samples * SMP) @(negedge clk);
    endtask

    task automatic start(input bit inv, input int nthr, input int ithr, input string t);
        en = 1'b0;
        @(negedge clk);
        invert    = inv;
        noise_thr = 6'(nthr);
        idle_thr  = 8'(ithr);
        ir_in     = inv;
        tag       = t;
        @(negedge clk);
        en = 1'b1;
        t0 = cyc;
    endtask

    task automatic settle(input string req);
        repeat (200) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor: pops the scoreboard as codes and packet ends appear
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(prev_valid && code_valid), "R9", 1, 0);
            prev_valid = code_valid;
            if (code_valid) begin
                if (arm_t) begin
                    check(cyc - t0 == 129, "R1", cyc - t0, 129);
                    arm_t = 0;
                end
                if (exp_q.size() == 0) begin
                    check(0, {tag, " unexpected code"}, code, 0);
                end else begin
                    automatic logic [8:0] e = exp_q.pop_front();
                    check(e == {1'b0, code}, tag, {1'b0, code}, e);
                end
            end
            if (pkt_end) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected end", 9'h100, 0);
                end else begin
                    automatic logic [8:0] e = exp_q.pop_front();
                    check(e == 9'h100, "R6 end", 9'h100, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(code_valid == 1'b0, "R10", code_valid, 0);
        check(pkt_end == 1'b0, "R10", pkt_end, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 timing, then R7 quiet after packet end
        start(0, 0, 0, "R1");
        arm_t = 1;
        push_run(1, 1); push_end();
        drive(1, 1); drive(0, 135);
        settle("R6");
        drive(0, 130);
        settle("R7");

        // R2 basic format, R7 leading idle
        start(0, 0, 0, "R2");
        drive(0, 20);
        push_run(1, 10); push_run(0, 5); push_run(1, 3); push_end();
        drive(1, 10); drive(0, 5); drive(1, 3); drive(0, 135);
        settle("R2");

        // R3 chunk boundaries: 300, 128, 129 samples
        start(0, 0, 0, "R3");
        push_run(1, 300); push_run(0, 10); push_run(1, 128);
        push_run(0, 10); push_run(1, 129); push_end();
        drive(1, 300); drive(0, 10); drive(1, 128);
        drive(0, 10); drive(1, 129); drive(0, 135);
        settle("R3");

        // R6 timeout with idle_thr=1 (256 samples, two space chunks)
        start(0, 0, 1, "R6");
        push_run(1, 4); exp_q.push_back({1'b0, 8'h7F}); push_end();
        drive(1, 4); drive(0, 262);
        settle("R6");

        // R4 inverted input
        start(1, 0, 0, "R4");
        push_run(1, 10); push_run(0, 5); push_run(1, 3); push_end();
        drive(1, 10); drive(0, 5); drive(1, 3); drive(0, 135);
        settle("R4");

        // R5 glitch filter, threshold 2
        start(0, 2, 0, "R5");
        drive(0, 10); drive(1, 2); drive(0, 10);
        settle("R5");
        push_run(1, 22); push_end();
        drive(1, 10); drive(0, 2); drive(1, 10); drive(0, 135);
        settle("R5");
        push_run(1, 10); push_run(0, 3); push_run(1, 10); push_end();
        drive(1, 10); drive(0, 3); drive(1, 10); drive(0, 135);
        settle("R5");

        // R8 disable drops partial run
        start(0, 0, 0, "R8");
        drive(1, 50);
        en = 1'b0;
        repeat (200) @(negedge clk);
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        start(0, 0, 0, "R8");
        push_run(1, 5); push_end();
        drive(1, 5); drive(0, 135);
        settle("R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule